// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the fetch program counter of a 32-bit pipeline that uses delayed control transfers. Each cycle it receives the decoded fields of the instruction now executing: a branch request with its kind and 4-bit condition code, the Z/N/V/C flags, a base register operand with a 16-bit offset, a word constant for absolute targets, and strobes that report an ALU result or a load result written to the PC. It evaluates the condition, forms the target and schedules the redirect behind the right number of delay slots. A stall input freezes the sequencer.

The conditional-set kind does not redirect. It reports the evaluated condition as a 0 or 1 register value on the same cycle, so the register file can write it. Only one redirect can be pending at a time. The first accepted redirect owns the pending slot until it lands.

Top module: `pcseq_top`

## Requirements
- R1: After reset the fetch address is 0 and no redirect is pending.
- R2: On each non-stalled cycle with no redirect landing, the fetch address grows by 4.
- R3: The condition code is {sel[2:0], inv}. When inv=1 the base condition is inverted. The base conditions for sel 0..7 are: 0 true, 1 C&~Z, 2 ~C, 3 ~Z, 4 ~V, 5 ~N, 6 N==V, 7 ~Z&(N==V). All 16 codes follow from this.
- R4: Kind 0 (absolute) targets the constant word zero-extended and shifted left by 2. This covers 0 to 2^25-4.
- R5: Kind 1 (relative) targets the base operand plus 4 times the sign-extended 16-bit offset.
- R6: A branch whose condition is false, or kind 3, has no effect on the fetch sequence.
- R7: A taken branch issued while the fetch address is P gives the fetch sequence P+4 (the single delay slot) and then the target.
- R8: An ALU write to the PC redirects to the write data after one delay slot.
- R9: A load write to the PC redirects to the write data after two delay slots (P+4, P+8, then the target).
- R10: Kind 2 (conditional set) raises set_wr_o in the same cycle with set_val_o equal to 1 or 0 by the condition. It never redirects.
- R11: While stall_i is high, the fetch address and the pending redirect hold, and no new request is accepted.
- R12: A redirect request that arrives while another is pending is ignored. The first target wins.
- R13: Requests that arrive in the same cycle are ranked load write first, then ALU write, then branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze sequencer this cycle |
| br_issue_i | input | 1 | A branch-format instruction executes |
| br_kind_i | input | 2 | 0 absolute, 1 relative, 2 conditional set, 3 reserved |
| cond_i | input | 4 | Condition code {sel, inv} |
| abs_word_i | input | 23 | Absolute target word address |
| base_i | input | 32 | Base register operand for relative kind |
| offset_i | input | 16 | Signed word offset for relative kind |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| alu_pc_wr_i | input | 1 | ALU result targets the PC |
| ld_pc_wr_i | input | 1 | Load result targets the PC |
| wr_data_i | input | 32 | Data written to the PC |
| fetch_pc_o | output | 32 | Current fetch address |
| set_wr_o | output | 1 | Conditional-set result valid |
| set_val_o | output | 32 | Conditional-set result, 0 or 1 |

## Verification
The conditional-set result is combinational, so the bench checks it one time unit after driving the inputs, in the same cycle. Every other result shows up in fetch_pc_o one register stage after the clock edge that closes the cycle. The driver pushes the expected fetch address for that edge into a queue. A monitor pops it just after the edge and compares. A redirect with one slot therefore lands two edges after its request cycle, and one with two slots lands three edges after. Stalled cycles add edges where the expected address repeats.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   typedef enum logic [1:0] {
      BK_ABS = 2'd0,
      BK_REL = 2'd1,
      BK_SET = 2'd2,
      BK_RSV = 2'd3
   } br_kind_e;

   localparam int unsigned PC_STEP = 4;

   // base condition for selector s (before the invert bit)
   function automatic logic base_cond(input logic [2:0] s, input logic z,
                                      input logic n, input logic v, input logic c);
      logic r;
      case (s)
         3'd0: r = 1'b1;
         3'd1: r = c & ~z;
         3'd2: r = ~c;
         3'd3: r = ~z;
         3'd4: r = ~v;
         3'd5: r = ~n;
         3'd6: r = ~(n ^ v);
         default: r = ~z & ~(n ^ v);
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pcseq_cond_eval.sv
module pcseq_cond_eval
   import pcseq_pkg::*;
#(
   parameter int unsigned CC_W = 4
) (
   input  logic [CC_W-1:0] cond_i,
   input  logic            z_i,
   input  logic            n_i,
   input  logic            v_i,
   input  logic            c_i,
   output logic            hit_o
);
   localparam int unsigned SEL_W = CC_W - 1;
   localparam int unsigned N_SEL = 1 << SEL_W;

   logic [N_SEL-1:0] base_vec;

   generate
      for (genvar s = 0; s < N_SEL; s++) begin : g_sel
         assign base_vec[s] = base_cond(3'(s), z_i, n_i, v_i, c_i);
      end
   endgenerate

   assign hit_o = base_vec[cond_i[CC_W-1:1]] ^ cond_i[0];

   initial begin
      a_r3_cc_width: assert (CC_W == 4);
   end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
   import pcseq_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned ABS_W = 23,
   parameter int unsigned OFF_W = 16
) (
   input  logic [1:0]       kind_i,
   input  logic [ABS_W-1:0] abs_word_i,
   input  logic [XLEN-1:0]  base_i,
   input  logic [OFF_W-1:0] offset_i,
   output logic [XLEN-1:0]  target_o
);
   localparam int unsigned ABS_PAD = XLEN - ABS_W - 2;
   localparam int unsigned OFF_PAD = XLEN - OFF_W;

   logic [XLEN-1:0] abs_tgt;
   logic [XLEN-1:0] off_ext;
   logic [XLEN-1:0] rel_tgt;

   generate
      if (ABS_PAD > 0) begin : g_abs_pad
         assign abs_tgt = {{ABS_PAD{1'b0}}, abs_word_i, 2'b00};
      end else begin : g_abs_full
         assign abs_tgt = {abs_word_i, 2'b00};
      end
   endgenerate

   assign off_ext = {{OFF_PAD{offset_i[OFF_W-1]}}, offset_i};
   assign rel_tgt = base_i + {off_ext[XLEN-3:0], 2'b00};

   always_comb begin
      case (br_kind_e'(kind_i))
         BK_REL:  target_o = rel_tgt;
         default: target_o = abs_tgt;
      endcase
   end
endmodule

// File: rtl/pcseq_redirect.sv
module pcseq_redirect
   import pcseq_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned SLOT_BR = 1,
   parameter int unsigned SLOT_LD = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            stall_i,
   input  logic            req_br_i,
   input  logic            req_alu_i,
   input  logic            req_ld_i,
   input  logic [XLEN-1:0] br_tgt_i,
   input  logic [XLEN-1:0] wr_data_i,
   output logic [XLEN-1:0] pc_o
);
   localparam int unsigned CNT_W = $clog2(SLOT_LD + 1);

   logic [XLEN-1:0]  pc_q, tgt_q, sel_tgt;
   logic [CNT_W-1:0] cnt_q, sel_cnt;
   logic             any_req, accept, land;

   assign any_req = req_br_i | req_alu_i | req_ld_i;
   assign accept  = any_req & ~stall_i & (cnt_q == '0);
   assign land    = ~stall_i & (cnt_q == CNT_W'(1));

   // load write outranks ALU write, which outranks branch
   always_comb begin
      if (req_ld_i) begin
         sel_tgt = wr_data_i;
         sel_cnt = CNT_W'(SLOT_LD);
      end else if (req_alu_i) begin
         sel_tgt = wr_data_i;
         sel_cnt = CNT_W'(SLOT_BR);
      end else begin
         sel_tgt = br_tgt_i;
         sel_cnt = CNT_W'(SLOT_BR);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pc_q  <= '0;
         tgt_q <= '0;
         cnt_q <= '0;
      end else if (!stall_i) begin
         if (land) begin
            pc_q  <= tgt_q;
            cnt_q <= '0;
         end else begin
            pc_q <= pc_q + XLEN'(PC_STEP);
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end else if (accept) begin
               cnt_q <= sel_cnt;
               tgt_q <= sel_tgt;
            end
         end
      end
   end

   assign pc_o = pc_q;

   a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |=> ($stable(pc_q) && $stable(cnt_q) && $stable(tgt_q)));

   a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && cnt_q == '0) |=> pc_q == $past(pc_q) + XLEN'(PC_STEP));

   a_r7_land: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && cnt_q == CNT_W'(1)) |=> pc_q == $past(tgt_q));

   a_r12_first_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0) |=> $stable(tgt_q));

   a_r9_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(SLOT_LD));
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
   import pcseq_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned ABS_W   = 23,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned SLOT_BR = 1,
   parameter int unsigned SLOT_LD = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stall_i,
   input  logic             br_issue_i,
   input  logic [1:0]       br_kind_i,
   input  logic [3:0]       cond_i,
   input  logic [ABS_W-1:0] abs_word_i,
   input  logic [XLEN-1:0]  base_i,
   input  logic [OFF_W-1:0] offset_i,
   input  logic             flag_z_i,
   input  logic             flag_n_i,
   input  logic             flag_v_i,
   input  logic             flag_c_i,
   input  logic             alu_pc_wr_i,
   input  logic             ld_pc_wr_i,
   input  logic [XLEN-1:0]  wr_data_i,
   output logic [XLEN-1:0]  fetch_pc_o,
   output logic             set_wr_o,
   output logic [XLEN-1:0]  set_val_o
);
   generate
      if (SLOT_BR < 1 || SLOT_LD < SLOT_BR) begin : g_bad_slots
         $error("delay slot counts must satisfy 1 <= SLOT_BR <= SLOT_LD");
      end
      if (XLEN < ABS_W + 2 || XLEN <= OFF_W + 2) begin : g_bad_width
         $error("XLEN too narrow for the target fields");
      end
   endgenerate

   logic            cond_hit;
   logic [XLEN-1:0] br_tgt;
   logic            is_jump, is_set, req_br;

   pcseq_cond_eval #(.CC_W(4)) u_cond (
      .cond_i (cond_i),
      .z_i    (flag_z_i),
      .n_i    (flag_n_i),
      .v_i    (flag_v_i),
      .c_i    (flag_c_i),
      .hit_o  (cond_hit)
   );

   pcseq_target #(.XLEN(XLEN), .ABS_W(ABS_W), .OFF_W(OFF_W)) u_tgt (
      .kind_i     (br_kind_i),
      .abs_word_i (abs_word_i),
      .base_i     (base_i),
      .offset_i   (offset_i),
      .target_o   (br_tgt)
   );

   assign is_jump = br_issue_i & ((br_kind_e'(br_kind_i) == BK_ABS) |
                                  (br_kind_e'(br_kind_i) == BK_REL));
   assign is_set  = br_issue_i & (br_kind_e'(br_kind_i) == BK_SET);
   assign req_br  = is_jump & cond_hit;

   pcseq_redirect #(.XLEN(XLEN), .SLOT_BR(SLOT_BR), .SLOT_LD(SLOT_LD)) u_redir (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stall_i   (stall_i),
      .req_br_i  (req_br),
      .req_alu_i (alu_pc_wr_i),
      .req_ld_i  (ld_pc_wr_i),
      .br_tgt_i  (br_tgt),
      .wr_data_i (wr_data_i),
      .pc_o      (fetch_pc_o)
   );

   assign set_wr_o  = is_set & ~stall_i;
   assign set_val_o = {{(XLEN-1){1'b0}}, cond_hit};

   a_r10_set_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_wr_o && !alu_pc_wr_i && !ld_pc_wr_i && fetch_pc_o == '0) |=> fetch_pc_o != '0);
endmodule

// File: tb/pcseq_top_tb.sv
module pcseq_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall, issue, alu_wr, ld_wr;
   logic [1:0]  kind;
   logic [3:0]  cc;
   logic [22:0] aw;
   logic [31:0] base, wd;
   logic [15:0] off;
   logic        fz, fn, fv, fc;
   logic [31:0] pc;
   logic        set_wr;
   logic [31:0] set_val;

   int checks = 0;
   int errors = 0;
   logic [31:0] cur;

   typedef struct { logic [31:0] pc; string tag; } exp_t;
   exp_t sbq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pcseq_top u_dut (
      .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .br_issue_i(issue),
      .br_kind_i(kind), .cond_i(cc), .abs_word_i(aw), .base_i(base),
      .offset_i(off), .flag_z_i(fz), .flag_n_i(fn), .flag_v_i(fv),
      .flag_c_i(fc), .alu_pc_wr_i(alu_wr), .ld_pc_wr_i(ld_wr),
      .wr_data_i(wd), .fetch_pc_o(pc), .set_wr_o(set_wr), .set_val_o(set_val)
   );

   function automatic logic ref_cond(input logic [3:0] k, input logic z,
                                     input logic n, input logic v, input logic c);
      logic b;
      unique case (k[3:1])
         3'd0: b = 1'b1;
         3'd1: b = c && !z;
         3'd2: b = !c;
         3'd3: b = !z;
         3'd4: b = !v;
         3'd5: b = !n;
         3'd6: b = (n == v);
         default: b = !z && (n == v);
      endcase
      return k[0] ? !b : b;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic idle_inputs();
      stall = 0; issue = 0; alu_wr = 0; ld_wr = 0; kind = 0; cc = 0;
      aw = 0; base = 0; wd = 0; off = 0; fz = 0; fn = 0; fv = 0; fc = 0;
   endtask

   // driver: queue the expected address for the coming edge, then advance
   task automatic cyc(input logic [31:0] expv, input string tag);
      exp_t e;
      e.pc = expv; e.tag = tag;
      sbq.push_back(e);
      cur = expv;
      @(negedge clk);
      idle_inputs();
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         chk(pc, e.pc, e.tag);
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(pc, 32'h0, "R1 reset pc");
      @(negedge clk);
      // first edge already passed with rst high: pc is 4 now
      chk(pc, 32'h4, "R2 first step");
      cur = 32'h4;
      cyc(cur + 4, "R2 step");
      cyc(cur + 4, "R2 step");

      // R6 false condition and reserved kind
      issue = 1; kind = 2'd0; cc = 4'b0001; aw = 23'h55;
      cyc(cur + 4, "R6 not taken");
      issue = 1; kind = 2'd3; cc = 4'b0000; aw = 23'h55;
      cyc(cur + 4, "R6 reserved kind");
      cyc(cur + 4, "R6 no late redirect");

      // R7 / R4 absolute taken
      issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h100;
      cyc(cur + 4, "R7 delay slot");
      cyc(32'h400, "R4 R7 abs target");
      issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h7FFFFF;
      cyc(cur + 4, "R7 delay slot");
      cyc(32'h01FF_FFFC, "R4 max target");

      // R5 relative, Z condition
      issue = 1; kind = 2'd1; cc = 4'b0111; fz = 1; base = 32'h1000; off = 16'hFFFE;
      cyc(cur + 4, "R5 delay slot");
      cyc(32'h0000_0FF8, "R5 negative offset");
      issue = 1; kind = 2'd1; cc = 4'b1100; fn = 1; fv = 1; base = 32'h2000; off = 16'h0010;
      cyc(cur + 4, "R5 delay slot");
      cyc(32'h0000_2040, "R5 positive offset");

      // R8 ALU write
      alu_wr = 1; wd = 32'h0000_3000;
      cyc(cur + 4, "R8 shadow");
      cyc(32'h0000_3000, "R8 alu target");

      // R9 load write
      ld_wr = 1; wd = 32'h0000_5000;
      cyc(cur + 4, "R9 slot one");
      cyc(cur + 4, "R9 slot two");
      cyc(32'h0000_5000, "R9 load target");

      // R12 second request while pending
      issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h200;
      cyc(cur + 4, "R12 slot");
      alu_wr = 1; wd = 32'h0000_9000;
      cyc(32'h800, "R12 first target wins");
      cyc(cur + 4, "R12 no late second");

      // R13 simultaneous load and branch
      ld_wr = 1; wd = 32'h0000_6000; issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h300;
      cyc(cur + 4, "R13 slot one");
      cyc(cur + 4, "R13 slot two");
      cyc(32'h0000_6000, "R13 load outranks branch");
      alu_wr = 1; wd = 32'h0000_7000; issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h300;
      cyc(cur + 4, "R13 slot");
      cyc(32'h0000_7000, "R13 alu outranks branch");

      // R11 stall during pending and on request
      issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h040;
      cyc(cur + 4, "R11 slot");
      stall = 1;
      cyc(cur, "R11 hold");
      stall = 1;
      cyc(cur, "R11 hold");
      cyc(32'h100, "R11 lands after stall");
      stall = 1; issue = 1; kind = 2'd0; cc = 4'b0000; aw = 23'h0A0;
      cyc(cur, "R11 stalled request");
      cyc(cur + 4, "R11 stalled request dropped");
      cyc(cur + 4, "R11 stalled request dropped");

      // R3 / R10 full condition table via conditional set
      for (int k = 0; k < 16; k++) begin
         for (int f = 0; f < 16; f++) begin
            issue = 1; kind = 2'd2; cc = 4'(k);
            fz = f[3]; fn = f[2]; fv = f[1]; fc = f[0];
            #1;
            chk({31'b0, set_wr}, 32'h1, "R10 set strobe");
            chk(set_val, {31'b0, ref_cond(4'(k), f[3], f[2], f[1], f[0])}, "R3 R10 cond value");
            cyc(cur + 4, "R10 no redirect");
         end
      end
      stall = 1; issue = 1; kind = 2'd2; #1;
      chk({31'b0, set_wr}, 32'h0, "R10 set strobe stalled");
      cyc(cur, "R11 hold");

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule